// File: doc/BRIEF.md
# Virtual Interface Maintenance Status

This block tells a hypervisor why its virtual CPU interface needs attention. It watches the hypervisor's maintenance-interrupt enables, the guest's two group enables, the state of every list entry, an end-of-interrupt status vector and an end-of-interrupt counter. From these inputs it forms an 8-bit condition set, one bit per maintenance reason. Each bit is recomputed every cycle from the current inputs.

The condition set can be read as a 32-bit read-only word through a small register read port. The reasons that are present are also merged into one maintenance interrupt line. That line is registered and is qualified by the global virtual-interface enable. The global enable acts only on the interrupt line; the readable word always shows the raw conditions.

Top module: `vif_maint_status`

## Requirements
- R1: While `rst` is high, `rd_data` reads zero and, one clock after `rst` is seen high, `maint_irq` is 0. Bits 31..8 of `rd_data` are always zero.
- R2: Bit 7 = `ie_g1_off` AND NOT `vm_g1_en`. Bit 6 = `ie_g1_on` AND `vm_g1_en`.
- R3: Bit 5 = `ie_g0_off` AND NOT `vm_g0_en`. Bit 4 = `ie_g0_on` AND `vm_g0_en`.
- R4: Bit 3 = `ie_no_pend` AND no entry holds state code 2'b01. Entry i occupies `lr_state[2i+1:2i]`, with 00 = empty, 01 = pending, 10 = active and 11 = active and pending. An entry in state 11 does not count as pending.
- R5: Bit 2 = `ie_not_present` AND (`eoi_count` != 0).
- R6: Bit 1 = `ie_underflow` AND (the number of entries whose state is not 00 is 0 or 1).
- R7: Bit 0 = OR of all bits of `eoi_status`. This bit has no enable.
- R8: `maint_irq` equals (`hyp_en` AND any of bits 7..0 set), sampled at the previous rising clock edge. `hyp_en` has no effect on `rd_data`.
- R9: `rd_data` returns the condition word only when `rd_en` is high and `rd_addr` equals 0x010. For any other address, or when `rd_en` is low, it reads zero.
- R10: A write (`wr_en`, `wr_addr`, `wr_data`), including one to offset 0x010, changes neither `rd_data` nor `maint_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hyp_en | input | 1 | Global virtual-interface enable; qualifies the interrupt line |
| ie_g1_off | input | 1 | Enable for the group 1 disabled condition |
| ie_g1_on | input | 1 | Enable for the group 1 enabled condition |
| ie_g0_off | input | 1 | Enable for the group 0 disabled condition |
| ie_g0_on | input | 1 | Enable for the group 0 enabled condition |
| ie_no_pend | input | 1 | Enable for the no-pending condition |
| ie_not_present | input | 1 | Enable for the entry-not-present condition |
| ie_underflow | input | 1 | Enable for the underflow condition |
| vm_g0_en | input | 1 | Guest group 0 enable |
| vm_g1_en | input | 1 | Guest group 1 enable |
| lr_state | input | 2*N_LR | Two-bit state of each list entry |
| eoi_status | input | N_LR | End-of-interrupt status, one bit per entry |
| eoi_count | input | 5 | End-of-interrupt counter |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | 32 | Read data |
| wr_en | input | 1 | Write strobe (ignored) |
| wr_addr | input | ADDR_W | Write byte offset (ignored) |
| wr_data | input | 32 | Write data (ignored) |
| maint_irq | output | 1 | Registered maintenance interrupt |

## Verification
The bench builds the block with its defaults: four list entries and a 12-bit offset. With four entries, the bench can reach occupancy of zero, one, two and four valid entries. It can also mix all four state codes in one vector, so an active-and-pending entry sits beside an empty one and a pending one. The 5-bit counter is taken to both 1 and its maximum of 31, and end-of-interrupt status is raised on the lowest entry and on the highest entry.

// File: rtl/vif_maint_pkg.sv
package vif_maint_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned COND_W = 8;
    localparam int unsigned EOIC_W = 5;

    typedef enum logic [1:0] {
        LR_EMPTY   = 2'b00,
        LR_PEND    = 2'b01,
        LR_ACT     = 2'b10,
        LR_ACTPEND = 2'b11
    } lr_state_e;

    // Field order is the readable bit order: g1_off is bit 7, eoi is bit 0.
    typedef struct packed {
        logic g1_off;
        logic g1_on;
        logic g0_off;
        logic g0_on;
        logic no_pend;
        logic not_pres;
        logic under;
        logic eoi;
    } cond_t;

    typedef struct packed {
        logic g1_off;
        logic g1_on;
        logic g0_off;
        logic g0_on;
        logic no_pend;
        logic not_pres;
        logic under;
    } hyp_ie_t;

    function automatic logic [WORD_W-1:0] to_word(cond_t c);
        return {{(WORD_W-COND_W){1'b0}}, c};
    endfunction

endpackage

// File: rtl/vif_lr_scan.sv
module vif_lr_scan
    import vif_maint_pkg::*;
#(
    parameter int unsigned N_LR = 4
) (
    input  logic [2*N_LR-1:0] lr_state,
    output logic              pend_any,
    output logic              valid_le1
);
    localparam int unsigned CNT_W = $clog2(N_LR + 1);

    logic [N_LR-1:0] is_pend;
    logic [N_LR-1:0] is_valid;
    logic [CNT_W-1:0] valid_cnt;

    for (genvar i = 0; i < N_LR; i++) begin : g_entry
        lr_state_e st;
        assign st          = lr_state_e'(lr_state[2*i +: 2]);
        assign is_pend[i]  = (st == LR_PEND);
        assign is_valid[i] = (st != LR_EMPTY);
    end

    always_comb begin
        valid_cnt = '0;
        for (int i = 0; i < N_LR; i++) begin
            valid_cnt = valid_cnt + CNT_W'(is_valid[i]);
        end
    end

    assign pend_any  = |is_pend;
    assign valid_le1 = (valid_cnt <= CNT_W'(1));
endmodule

// File: rtl/vif_cond_build.sv
module vif_cond_build
    import vif_maint_pkg::*;
(
    input  hyp_ie_t ie,
    input  logic    vm_g0_en,
    input  logic    vm_g1_en,
    input  logic    pend_any,
    input  logic    valid_le1,
    input  logic    eoi_any,
    input  logic    cnt_nz,
    output cond_t   cond
);
    always_comb begin
        cond.g1_off   = ie.g1_off & ~vm_g1_en;
        cond.g1_on    = ie.g1_on  &  vm_g1_en;
        cond.g0_off   = ie.g0_off & ~vm_g0_en;
        cond.g0_on    = ie.g0_on  &  vm_g0_en;
        cond.no_pend  = ie.no_pend & ~pend_any;
        cond.not_pres = ie.not_pres & cnt_nz;
        cond.under    = ie.under & valid_le1;
        cond.eoi      = eoi_any;
    end
endmodule

// File: rtl/vif_irq_reg.sv
module vif_irq_reg
    import vif_maint_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  hyp_en,
    input  cond_t cond,
    output logic  irq
);
    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= hyp_en & (|cond);
    end
endmodule

// File: rtl/vif_maint_status.sv
module vif_maint_status
    import vif_maint_pkg::*;
#(
    parameter int unsigned N_LR       = 4,
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned REG_OFFSET = 'h010
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                hyp_en,
    input  logic                ie_g1_off,
    input  logic                ie_g1_on,
    input  logic                ie_g0_off,
    input  logic                ie_g0_on,
    input  logic                ie_no_pend,
    input  logic                ie_not_present,
    input  logic                ie_underflow,
    input  logic                vm_g0_en,
    input  logic                vm_g1_en,
    input  logic [2*N_LR-1:0]   lr_state,
    input  logic [N_LR-1:0]     eoi_status,
    input  logic [EOIC_W-1:0]   eoi_count,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [WORD_W-1:0]   rd_data,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [WORD_W-1:0]   wr_data,
    output logic                maint_irq
);
    localparam logic [ADDR_W-1:0] OFF = ADDR_W'(REG_OFFSET);

    hyp_ie_t ie;
    cond_t   cond_raw;
    cond_t   cond;
    logic    pend_any;
    logic    valid_le1;

    assign ie = '{g1_off: ie_g1_off, g1_on: ie_g1_on, g0_off: ie_g0_off,
                  g0_on: ie_g0_on, no_pend: ie_no_pend,
                  not_pres: ie_not_present, under: ie_underflow};

    vif_lr_scan #(.N_LR(N_LR)) scan_i (
        .lr_state  (lr_state),
        .pend_any  (pend_any),
        .valid_le1 (valid_le1)
    );

    vif_cond_build build_i (
        .ie        (ie),
        .vm_g0_en  (vm_g0_en),
        .vm_g1_en  (vm_g1_en),
        .pend_any  (pend_any),
        .valid_le1 (valid_le1),
        .eoi_any   (|eoi_status),
        .cnt_nz    (eoi_count != '0),
        .cond      (cond_raw)
    );

    // Conditions read as their reset value while reset is held.
    assign cond = rst ? '0 : cond_raw;

    vif_irq_reg irq_i (
        .clk    (clk),
        .rst    (rst),
        .hyp_en (hyp_en),
        .cond   (cond),
        .irq    (maint_irq)
    );

    // Read-only: the write port is decoded nowhere.
    assign rd_data = (rd_en && rd_addr == OFF) ? to_word(cond) : '0;
endmodule

// File: rtl/vif_maint_status_chk.sv
module vif_maint_status_chk
    import vif_maint_pkg::*;
#(
    parameter int unsigned N_LR       = 4,
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned REG_OFFSET = 'h010
) (
    input logic              clk,
    input logic              rst,
    input logic              hyp_en,
    input logic              ie_g1_off,
    input logic              ie_no_pend,
    input logic [2*N_LR-1:0] lr_state,
    input logic [N_LR-1:0]   eoi_status,
    input logic [EOIC_W-1:0] eoi_count,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [WORD_W-1:0] rd_data,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [WORD_W-1:0] wr_data,
    input logic              maint_irq
);
    localparam logic [ADDR_W-1:0] OFF = ADDR_W'(REG_OFFSET);
    logic hit;
    assign hit = rd_en && (rd_addr == OFF);

    p_upper_zero_r1: assert property (@(posedge clk) disable iff (rst)
        rd_data[WORD_W-1:COND_W] == '0);

    p_reset_irq_r1: assert property (@(posedge clk)
        rst |=> !maint_irq);

    p_g1_excl_r2: assert property (@(posedge clk) disable iff (rst)
        hit |-> !(rd_data[7] && rd_data[6]));

    p_g0_excl_r3: assert property (@(posedge clk) disable iff (rst)
        hit |-> !(rd_data[5] && rd_data[4]));

    p_g1off_gate_r2: assert property (@(posedge clk) disable iff (rst)
        (hit && !ie_g1_off) |-> !rd_data[7]);

    p_np_gate_r4: assert property (@(posedge clk) disable iff (rst)
        (hit && !ie_no_pend) |-> !rd_data[3]);

    p_eoi_any_r7: assert property (@(posedge clk) disable iff (rst)
        (hit && (|eoi_status)) |-> rd_data[0]);

    p_irq_gate_r8: assert property (@(posedge clk) disable iff (rst)
        !hyp_en |=> !maint_irq);

    p_irq_set_r8: assert property (@(posedge clk) disable iff (rst)
        (hit && hyp_en && rd_data[COND_W-1:0] != '0) |=> maint_irq);

    p_off_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (!rd_en || rd_addr != OFF) |-> rd_data == '0);

    p_wr_noeffect_r10: assert property (@(posedge clk) disable iff (rst)
        (hit && wr_en && wr_addr == OFF && wr_data != rd_data) ##1
        (hit && $stable(lr_state) && $stable(eoi_status) &&
         $stable(eoi_count) && $stable(ie_no_pend) && $stable(ie_g1_off))
        |-> $stable(rd_data[3:0]));
endmodule

bind vif_maint_status vif_maint_status_chk #(
    .N_LR(N_LR), .ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)
) chk_i (
    .clk(clk), .rst(rst), .hyp_en(hyp_en), .ie_g1_off(ie_g1_off),
    .ie_no_pend(ie_no_pend), .lr_state(lr_state), .eoi_status(eoi_status),
    .eoi_count(eoi_count), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .maint_irq(maint_irq)
);

// File: tb/vif_maint_status_tb.sv
`timescale 1ns/1ps
module vif_maint_status_tb_top;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        hyp_en, ie_g1_off, ie_g1_on, ie_g0_off, ie_g0_on;
    logic        ie_no_pend, ie_not_present, ie_underflow, vm_g0_en, vm_g1_en;
    logic [2*N-1:0] lr_state;
    logic [N-1:0]   eoi_status;
    logic [4:0]     eoi_count;
    logic           rd_en, wr_en;
    logic [11:0]    rd_addr, wr_addr;
    logic [31:0]    rd_data, wr_data;
    logic           maint_irq;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    vif_maint_status dut_i (
        .clk(clk), .rst(rst), .hyp_en(hyp_en),
        .ie_g1_off(ie_g1_off), .ie_g1_on(ie_g1_on),
        .ie_g0_off(ie_g0_off), .ie_g0_on(ie_g0_on),
        .ie_no_pend(ie_no_pend), .ie_not_present(ie_not_present),
        .ie_underflow(ie_underflow), .vm_g0_en(vm_g0_en), .vm_g1_en(vm_g1_en),
        .lr_state(lr_state), .eoi_status(eoi_status), .eoi_count(eoi_count),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .maint_irq(maint_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected condition byte computed from the requirement text.
    function automatic logic [7:0] model();
        logic pend = 1'b0;
        int   nval = 0;
        for (int i = 0; i < N; i++) begin
            if (lr_state[2*i +: 2] == 2'b01) pend = 1'b1;
            if (lr_state[2*i +: 2] != 2'b00) nval++;
        end
        return {ie_g1_off & !vm_g1_en, ie_g1_on & vm_g1_en,
                ie_g0_off & !vm_g0_en, ie_g0_on & vm_g0_en,
                ie_no_pend & !pend, ie_not_present & (eoi_count != 0),
                ie_underflow & (nval <= 1), |eoi_status};
    endfunction

    task automatic idle();
        hyp_en = 0; ie_g1_off = 0; ie_g1_on = 0; ie_g0_off = 0; ie_g0_on = 0;
        ie_no_pend = 0; ie_not_present = 0; ie_underflow = 0;
        vm_g0_en = 0; vm_g1_en = 0; lr_state = '0; eoi_status = '0;
        eoi_count = '0; rd_en = 1; rd_addr = 12'h010;
        wr_en = 0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic settle_read(input string req);
        #1;
        check(req, rd_data, {24'h0, model()});
    endtask

    task automatic t_reset();
        idle();
        rst = 1;
        ie_g1_off = 1; ie_no_pend = 1; ie_underflow = 1; hyp_en = 1; eoi_status = 4'hF;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        check("R1 reset word", rd_data, 32'h0);
        check("R1 reset irq", {31'h0, maint_irq}, 32'h0);
        rst = 0;
        idle();
    endtask

    task automatic t_groups();
        for (int v = 0; v < 16; v++) begin
            @(negedge clk); idle();
            {ie_g1_off, ie_g1_on, ie_g0_off, ie_g0_on} = 4'hF;
            vm_g1_en = v[0]; vm_g0_en = v[1];
            ie_g1_on = v[2]; ie_g0_off = v[3];
            ie_no_pend = 0;
            settle_read(v[0] ? "R2 group1" : "R3 group0");
        end
    endtask

    task automatic t_nopend();
        logic [7:0] pats [5] = '{8'h00, 8'h01, 8'hFF, 8'hEE, 8'h4E};
        foreach (pats[k]) begin
            @(negedge clk); idle();
            ie_no_pend = 1; lr_state = pats[k];
            settle_read("R4 no pending");
        end
        @(negedge clk); idle(); ie_no_pend = 1; lr_state = 8'b11_11_10_00; #1;
        check("R4 active+pending not pending", {31'h0, rd_data[3]}, 32'h1);
    endtask

    task automatic t_notpresent();
        logic [4:0] cnts [3] = '{5'd0, 5'd1, 5'd31};
        foreach (cnts[k]) begin
            @(negedge clk); idle();
            ie_not_present = 1; eoi_count = cnts[k];
            settle_read("R5 entry not present");
        end
    endtask

    task automatic t_underflow();
        logic [7:0] pats [5] = '{8'h00, 8'h30, 8'h0C, 8'h22, 8'hFF};
        foreach (pats[k]) begin
            @(negedge clk); idle();
            ie_underflow = 1; lr_state = pats[k];
            settle_read("R6 underflow");
        end
    endtask

    task automatic t_eoi();
        logic [3:0] pats [3] = '{4'h0, 4'h1, 4'h8};
        foreach (pats[k]) begin
            @(negedge clk); idle();
            eoi_status = pats[k];
            settle_read("R7 end of interrupt");
        end
    endtask

    task automatic t_irq();
        @(negedge clk); idle(); eoi_status = 4'h2; hyp_en = 0; #1;
        check("R8 word not gated by enable", rd_data, 32'h1);
        @(negedge clk); #1;
        check("R8 irq off when disabled", {31'h0, maint_irq}, 32'h0);
        hyp_en = 1; #1;
        check("R8 irq not yet", {31'h0, maint_irq}, 32'h0);
        @(negedge clk); #1;
        check("R8 irq after one edge", {31'h0, maint_irq}, 32'h1);
        eoi_status = 0;
        @(negedge clk); #1;
        check("R8 irq drops", {31'h0, maint_irq}, 32'h0);
    endtask

    task automatic t_decode();
        @(negedge clk); idle(); ie_g1_off = 1; eoi_status = 4'h1;
        rd_addr = 12'h014; #1;
        check("R9 other offset", rd_data, 32'h0);
        rd_addr = 12'h000; #1;
        check("R9 offset zero", rd_data, 32'h0);
        rd_addr = 12'h010; rd_en = 0; #1;
        check("R9 no strobe", rd_data, 32'h0);
        rd_en = 1; #1;
        check("R9 hit", rd_data, 32'h81);
    endtask

    task automatic t_write();
        @(negedge clk); idle(); ie_no_pend = 1; hyp_en = 1;
        wr_en = 1; wr_addr = 12'h010; wr_data = 32'h0000_0000;
        @(negedge clk); wr_data = 32'hFFFF_FFFF; #1;
        check("R10 write ignored word", rd_data, 32'h08);
        @(negedge clk); #1;
        check("R10 write ignored irq", {31'h0, maint_irq}, 32'h1);
        wr_en = 0;
    endtask

    initial begin
        #100000;
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_groups();
        t_nopend();
        t_notpresent();
        t_underflow();
        t_eoi();
        t_irq();
        t_decode();
        t_write();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule